// File: doc/BRIEF.md
# Three-Channel Interval Timer Host Bus Interface

This block is the byte-wide register front end of a three-channel interval timer. A host reaches it through a 2-bit port address with a select and separate read and write strobes. The data bus is split into an input bus and an output bus. Three of the four ports belong one each to a counting channel. The fourth port takes control bytes. The upper bits of each control byte name the channel that the byte programs.

Each channel keeps its own byte-access format. The format can be low byte only, high byte only, or low byte then high byte. This lets a 16-bit divisor cross an 8-bit bus. Once the divisor is complete, the channel's count output takes the new value and a one-cycle load strobe is raised. Reads return count bytes in the same format. A latch command freezes a snapshot of the live count so that it can be read back. The counting logic sits outside this block. Each channel offers its live count to the block as an input and receives the divisor through its count and load outputs.

Each channel runs two small state machines, both with states `W_LO`/`W_HI` (write side) and `R_LO`/`R_HI` (read side):

- **Write side.** `W_LO` goes to `W_HI` on the first byte written in two-byte format. `W_HI` goes to `W_LO` on the second byte, and that transition completes the load. A programming control byte forces `W_LO`.
- **Read side.** `R_LO` and `R_HI` alternate on each read in two-byte format. A programming control byte forces `R_LO`.

Top module: `timer_bus_if`

## Requirements
- R1: After reset every load strobe is low, every count output is 0x0000, every mode is 0, every BCD flag is 0 and `rdata` is 0x00.
- R2: An access has an effect only while `sel` is high. Address 0, 1 and 2 reach channels 0, 1 and 2, and address 3 reaches the control port. A write takes priority over a read in the same cycle.
- R3: A control byte written to address 3 is laid out as follows: bits 7:6 name the channel, bits 5:4 give the format (01 low only, 10 high only, 11 low then high), bits 3:1 give the mode and bit 0 gives BCD. Mode and BCD appear on `ch_mode`/`ch_bcd` on the clock edge that takes the write. A channel value of 3 is ignored.
- R4: Data written to a channel is ignored until that channel has received a control byte with a non-zero format.
- R5: In low-only format, a data write sets the count to {0x00, byte}. The channel's load strobe is high for the cycle after that write.
- R6: In high-only format, a data write sets the count to {byte, 0x00} and raises the load strobe in the same way.
- R7: In low-then-high format, the first write only stores the byte and gives no load. The second write sets the count to {second, first} and raises the load strobe. A programming control byte to the channel restarts the sequence at the low byte.
- R8: A divisor of 0x0000 is passed unchanged to the count output with a load strobe.
- R9: A control byte with format 00 takes a snapshot of that channel's live count and leaves the mode and format unchanged. While a snapshot is still unread, further latch commands are ignored. The snapshot is released once a full read sequence of the channel's format has finished.
- R10: A read returns, on `rdata` one cycle after the strobe, the byte chosen by the channel's format and read toggle. The byte comes from the snapshot if one is held and from the live count otherwise. Reading address 3 returns 0x00. `rdata` holds its value between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Chip select, active high |
| rd_en | input | 1 | Read strobe, one cycle per byte |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| addr | input | 2 | Port address |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Registered read data byte |
| live_count | input | 48 | Live count of each channel, channel n at bits 16n+15:16n |
| ch_load | output | 3 | One-cycle strobe per channel when a new divisor is complete |
| ch_count | output | 48 | Divisor per channel, channel n at bits 16n+15:16n |
| ch_mode | output | 9 | Mode per channel, channel n at bits 3n+2:3n |
| ch_bcd | output | 3 | BCD flag per channel |

## Verification
The hardest situation to reach is a snapshot that outlives a change of the live count while the read toggle is halfway through a two-byte read. To reach it, the stimulus issues a latch command and then changes the live count. It sends a second latch command, which must be ignored, and then reads both bytes. A third read shows that the snapshot has been released, because it returns the new live value. Toggle restarts are reached by leaving a two-byte write half done and then reprogramming the channel before the next byte.

// File: rtl/tbi_pkg.sv
package tbi_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int MODE_W = 3;

    typedef enum logic [1:0] {
        ACC_LATCH = 2'b00,
        ACC_LSB   = 2'b01,
        ACC_MSB   = 2'b10,
        ACC_WORD  = 2'b11
    } access_t;

    typedef enum logic {
        W_LO = 1'b0,
        W_HI = 1'b1
    } wr_state_t;

    typedef enum logic {
        R_LO = 1'b0,
        R_HI = 1'b1
    } rd_state_t;
endpackage

// File: rtl/tbi_decode.sv
module tbi_decode #(
    parameter int N_CH = 3
) (
    input  logic            sel,
    input  logic            rd_en,
    input  logic            wr_en,
    input  logic [1:0]      addr,
    input  logic [1:0]      ctl_target,
    output logic [N_CH-1:0] ctl_we,
    output logic [N_CH-1:0] data_we,
    output logic [N_CH-1:0] data_re,
    output logic            ctl_rd
);
    logic wr_hit;
    logic rd_hit;
    logic is_ctl;

    assign wr_hit = sel && wr_en;
    assign rd_hit = sel && rd_en && !wr_en;
    assign is_ctl = (addr == 2'b11);
    assign ctl_rd = rd_hit && is_ctl;

    for (genvar i = 0; i < N_CH; i++) begin : g_port
        assign data_we[i] = wr_hit && !is_ctl && (addr == 2'(i));
        assign data_re[i] = rd_hit && !is_ctl && (addr == 2'(i));
        assign ctl_we[i]  = wr_hit && is_ctl && (ctl_target == 2'(i));
    end
endmodule

// File: rtl/tbi_channel.sv
module tbi_channel
    import tbi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic [5:0]        ctl_field,
    input  logic              data_we,
    input  logic              data_re,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [CNT_W-1:0]  live_count,
    output logic              load,
    output logic [CNT_W-1:0]  count,
    output logic [MODE_W-1:0] mode,
    output logic              bcd,
    output logic [BYTE_W-1:0] rd_byte
);
    access_t           fmt;
    logic              programmed;
    logic [BYTE_W-1:0] lo_hold, lo_hold_nx;
    logic [CNT_W-1:0]  snap;
    logic              snap_valid;
    wr_state_t         wst, wst_nx;
    rd_state_t         rst_q, rst_nx;
    logic              load_nx;
    logic [CNT_W-1:0]  count_nx;
    logic [CNT_W-1:0]  rd_src;
    logic              rd_done;

    access_t ctl_fmt;
    logic    is_latch;
    logic    is_prog;
    logic    wr_go;

    assign ctl_fmt  = access_t'(ctl_field[5:4]);
    assign is_latch = ctl_we && (ctl_fmt == ACC_LATCH);
    assign is_prog  = ctl_we && (ctl_fmt != ACC_LATCH);
    assign wr_go    = data_we && programmed;

    // state and data registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wst        <= W_LO;
            rst_q      <= R_LO;
            fmt        <= ACC_LSB;
            programmed <= 1'b0;
            mode       <= '0;
            bcd        <= 1'b0;
            lo_hold    <= '0;
            count      <= '0;
            load       <= 1'b0;
            snap       <= '0;
            snap_valid <= 1'b0;
        end else begin
            wst     <= wst_nx;
            rst_q   <= rst_nx;
            lo_hold <= lo_hold_nx;
            count   <= count_nx;
            load    <= load_nx;
            if (is_prog) begin
                fmt        <= ctl_fmt;
                mode       <= ctl_field[3:1];
                bcd        <= ctl_field[0];
                programmed <= 1'b1;
            end
            if (is_latch && !snap_valid) begin
                snap       <= live_count;
                snap_valid <= 1'b1;
            end else if (rd_done) begin
                snap_valid <= 1'b0;
            end
        end
    end

    // write-side next state and divisor assembly
    always_comb begin
        wst_nx     = wst;
        lo_hold_nx = lo_hold;
        count_nx   = count;
        load_nx    = 1'b0;
        if (is_prog) begin
            wst_nx = W_LO;
        end else if (wr_go) begin
            unique case (fmt)
                ACC_LSB: begin
                    count_nx = {{BYTE_W{1'b0}}, wdata};
                    load_nx  = 1'b1;
                end
                ACC_MSB: begin
                    count_nx = {wdata, {BYTE_W{1'b0}}};
                    load_nx  = 1'b1;
                end
                ACC_WORD: begin
                    unique case (wst)
                        W_LO: begin
                            lo_hold_nx = wdata;
                            wst_nx     = W_HI;
                        end
                        W_HI: begin
                            count_nx = {wdata, lo_hold};
                            load_nx  = 1'b1;
                            wst_nx   = W_LO;
                        end
                    endcase
                end
                default: ;
            endcase
        end
    end

    // read-side next state and byte selection
    always_comb begin
        rd_src  = snap_valid ? snap : live_count;
        rst_nx  = rst_q;
        rd_done = 1'b0;
        unique case (fmt)
            ACC_MSB:  rd_byte = rd_src[CNT_W-1:BYTE_W];
            ACC_WORD: rd_byte = (rst_q == R_HI) ? rd_src[CNT_W-1:BYTE_W]
                                                : rd_src[BYTE_W-1:0];
            default:  rd_byte = rd_src[BYTE_W-1:0];
        endcase
        if (is_prog) begin
            rst_nx = R_LO;
        end else if (data_re) begin
            if (fmt == ACC_WORD) begin
                unique case (rst_q)
                    R_LO: rst_nx = R_HI;
                    R_HI: begin
                        rst_nx  = R_LO;
                        rd_done = 1'b1;
                    end
                endcase
            end else begin
                rd_done = 1'b1;
            end
        end
    end
endmodule

// File: rtl/timer_bus_if.sv
module timer_bus_if
    import tbi_pkg::*;
#(
    parameter int N_CH = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sel,
    input  logic                     rd_en,
    input  logic                     wr_en,
    input  logic [1:0]               addr,
    input  logic [BYTE_W-1:0]        wdata,
    output logic [BYTE_W-1:0]        rdata,
    input  logic [N_CH*CNT_W-1:0]    live_count,
    output logic [N_CH-1:0]          ch_load,
    output logic [N_CH*CNT_W-1:0]    ch_count,
    output logic [N_CH*MODE_W-1:0]   ch_mode,
    output logic [N_CH-1:0]          ch_bcd
);
    logic [N_CH-1:0]   ctl_we;
    logic [N_CH-1:0]   data_we;
    logic [N_CH-1:0]   data_re;
    logic              ctl_rd;
    logic [BYTE_W-1:0] rd_byte [N_CH];
    logic [BYTE_W-1:0] rd_pick;

    tbi_decode #(.N_CH(N_CH)) u_decode (
        .sel        (sel),
        .rd_en      (rd_en),
        .wr_en      (wr_en),
        .addr       (addr),
        .ctl_target (wdata[7:6]),
        .ctl_we     (ctl_we),
        .data_we    (data_we),
        .data_re    (data_re),
        .ctl_rd     (ctl_rd)
    );

    for (genvar i = 0; i < N_CH; i++) begin : g_ch
        tbi_channel u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .ctl_we     (ctl_we[i]),
            .ctl_field  (wdata[5:0]),
            .data_we    (data_we[i]),
            .data_re    (data_re[i]),
            .wdata      (wdata),
            .live_count (live_count[i*CNT_W +: CNT_W]),
            .load       (ch_load[i]),
            .count      (ch_count[i*CNT_W +: CNT_W]),
            .mode       (ch_mode[i*MODE_W +: MODE_W]),
            .bcd        (ch_bcd[i]),
            .rd_byte    (rd_byte[i])
        );
    end

    always_comb begin
        rd_pick = '0;
        for (int i = 0; i < N_CH; i++) begin
            if (data_re[i]) rd_pick = rd_byte[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (|data_re) begin
            rdata <= rd_pick;
        end else if (ctl_rd) begin
            rdata <= '0;
        end
    end
endmodule

// File: rtl/timer_bus_if_chk.sv
module timer_bus_if_chk #(
    parameter int N_CH = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                sel,
    input logic                rd_en,
    input logic                wr_en,
    input logic [1:0]          addr,
    input logic [7:0]          rdata,
    input logic [N_CH-1:0]     ch_load,
    input logic [N_CH*16-1:0]  ch_count,
    input logic [N_CH*3-1:0]   ch_mode
);
    // R2
    sel_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> (ch_load == '0));

    // R2
    single_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_load));

    // R5
    load_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|ch_load) |-> $past(sel && wr_en && (addr != 2'b11)));

    // R4
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|ch_load) |-> $stable(ch_count));

    // R3
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel && wr_en && (addr == 2'b11)) |=> $stable(ch_mode));

    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel && rd_en && !wr_en) |=> $stable(rdata));
endmodule

bind timer_bus_if timer_bus_if_chk #(.N_CH(N_CH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (sel),
    .rd_en    (rd_en),
    .wr_en    (wr_en),
    .addr     (addr),
    .rdata    (rdata),
    .ch_load  (ch_load),
    .ch_count (ch_count),
    .ch_mode  (ch_mode)
);

// File: tb/tb_timer_bus_if.sv
`timescale 1ns/1ps
module tb_timer_bus_if;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [47:0] live_count = {16'h0A0B, 16'hBEEF, 16'h1234};
    logic [2:0]  ch_load;
    logic [47:0] ch_count;
    logic [8:0]  ch_mode;
    logic [2:0]  ch_bcd;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    timer_bus_if dut (
        .clk(clk), .rst_n(rst_n), .sel(sel), .rd_en(rd_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .live_count(live_count),
        .ch_load(ch_load), .ch_count(ch_count), .ch_mode(ch_mode), .ch_bcd(ch_bcd)
    );

    typedef struct packed {
        logic [1:0]  kind;   // 1 write, 2 read
        logic [1:0]  addr;
        logic [7:0]  data;
        logic [2:0]  eload;
        logic [15:0] ecnt;
        logic [7:0]  erd;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VEC [NV] = '{
        '{2'd1, 2'd0, 8'h55, 3'b000, 16'h0000, 8'h00, 4'd4},  // R4 before programming
        '{2'd1, 2'd3, 8'h14, 3'b000, 16'h0000, 8'h00, 4'd3},  // ch0 low only, mode 2
        '{2'd1, 2'd0, 8'h7A, 3'b001, 16'h007A, 8'h00, 4'd5},  // R5
        '{2'd1, 2'd3, 8'h67, 3'b000, 16'h0000, 8'h00, 4'd3},  // ch1 high only, mode 3, bcd
        '{2'd1, 2'd1, 8'h9C, 3'b010, 16'h9C00, 8'h00, 4'd6},  // R6
        '{2'd1, 2'd3, 8'hB6, 3'b000, 16'h0000, 8'h00, 4'd3},  // ch2 two-byte, mode 3
        '{2'd1, 2'd2, 8'h34, 3'b000, 16'h0000, 8'h00, 4'd7},  // R7 first byte
        '{2'd1, 2'd2, 8'h12, 3'b100, 16'h1234, 8'h00, 4'd7},
        '{2'd1, 2'd2, 8'h00, 3'b000, 16'h0000, 8'h00, 4'd8},  // R8
        '{2'd1, 2'd2, 8'h00, 3'b100, 16'h0000, 8'h00, 4'd8},
        '{2'd2, 2'd2, 8'h00, 3'b000, 16'h0000, 8'h0B, 4'd10}, // R10 live low
        '{2'd2, 2'd2, 8'h00, 3'b000, 16'h0000, 8'h0A, 4'd10}, // live high
        '{2'd2, 2'd0, 8'h00, 3'b000, 16'h0000, 8'h34, 4'd10},
        '{2'd2, 2'd1, 8'h00, 3'b000, 16'h0000, 8'hBE, 4'd10},
        '{2'd2, 2'd3, 8'h00, 3'b000, 16'h0000, 8'h00, 4'd10}, // control port reads 0
        '{2'd1, 2'd3, 8'hD4, 3'b000, 16'h0000, 8'h00, 4'd3},  // channel 3 ignored
        '{2'd1, 2'd2, 8'h56, 3'b000, 16'h0000, 8'h00, 4'd7},  // half-done pair
        '{2'd1, 2'd3, 8'hB6, 3'b000, 16'h0000, 8'h00, 4'd7},  // reprogram restarts
        '{2'd1, 2'd2, 8'h78, 3'b000, 16'h0000, 8'h00, 4'd7},
        '{2'd1, 2'd2, 8'h9A, 3'b100, 16'h9A78, 8'h00, 4'd7},
        '{2'd1, 2'd0, 8'hFF, 3'b001, 16'h00FF, 8'h00, 4'd5},
        '{2'd1, 2'd1, 8'h00, 3'b010, 16'h0000, 8'h00, 4'd8}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive one access at a negedge, return at the next negedge with outputs settled
    task automatic access(input bit s, input bit w, input bit r,
                          input logic [1:0] a, input logic [7:0] d);
        sel = s; wr_en = w; rd_en = r; addr = a; wdata = d;
        @(negedge clk);
        sel = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 load",  {13'd0, ch_load}, 16'h0);
        check("R1 count0", ch_count[15:0], 16'h0);
        check("R1 count2", ch_count[47:32], 16'h0);
        check("R1 mode",  {7'd0, ch_mode}, 16'h0);
        check("R1 bcd",   {13'd0, ch_bcd}, 16'h0);
        check("R1 rdata", {8'd0, rdata}, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            vec_t t;
            string tag;
            t = VEC[v];
            tag = $sformatf("R%0d vec%0d", t.req, v);
            access(1'b1, t.kind == 2'd1, t.kind == 2'd2, t.addr, t.data);
            check({tag, " load"}, {13'd0, ch_load}, {13'd0, t.eload});
            for (int c = 0; c < 3; c++) begin
                if (t.eload[c]) check({tag, " count"}, ch_count[c*16 +: 16], t.ecnt);
            end
            if (t.kind == 2'd2) check({tag, " rdata"}, {8'd0, rdata}, {8'd0, t.erd});
        end

        // R3 routed modes and flags; channel 3 byte had no effect
        check("R3 mode", {7'd0, ch_mode}, {7'd0, 3'd3, 3'd3, 3'd2});
        check("R3 bcd",  {13'd0, ch_bcd}, 16'b010);

        // R2 writes without select are ignored
        access(1'b0, 1'b1, 1'b0, 2'd0, 8'h11);
        check("R2 nosel load", {13'd0, ch_load}, 16'h0);
        check("R2 nosel count", ch_count[15:0], 16'h00FF);
        // R2 write wins over simultaneous read
        access(1'b1, 1'b1, 1'b1, 2'd0, 8'h22);
        check("R2 wr priority load", {13'd0, ch_load}, 16'b001);
        check("R2 wr priority rdata", {8'd0, rdata}, 16'h00);

        // R9 snapshot on a two-byte channel
        access(1'b1, 1'b1, 1'b0, 2'd3, 8'h80);
        live_count[47:32] = 16'h5555;
        access(1'b1, 1'b1, 1'b0, 2'd3, 8'h80);
        check("R9 mode kept", {13'd0, ch_mode[8:6]}, 16'd3);
        access(1'b1, 1'b0, 1'b1, 2'd2, 8'h00);
        check("R9 snap low", {8'd0, rdata}, 16'h0B);
        access(1'b1, 1'b0, 1'b1, 2'd2, 8'h00);
        check("R9 snap high", {8'd0, rdata}, 16'h0A);
        access(1'b1, 1'b0, 1'b1, 2'd2, 8'h00);
        check("R9 released", {8'd0, rdata}, 16'h55);

        // R9 snapshot on a high-only channel
        access(1'b1, 1'b1, 1'b0, 2'd3, 8'h40);
        live_count[31:16] = 16'h1111;
        access(1'b1, 1'b0, 1'b1, 2'd1, 8'h00);
        check("R9 single snap", {8'd0, rdata}, 16'hBE);
        access(1'b1, 1'b0, 1'b1, 2'd1, 8'h00);
        check("R10 live after release", {8'd0, rdata}, 16'h11);
        check("R9 no load", {13'd0, ch_load}, 16'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule